// File: doc/BRIEF.md
# Output driver strength step adjuster

This block is the device-side half of an output driver calibration. A memory controller selects adjust mode and then sends a four-beat serial code. Every data lane carries the same bit on each beat. The block collects the four beats and checks that all lanes agreed on every beat. It then turns the code into step commands for two independent drive-strength registers, one for the pull-up leg and one for the pull-down leg. The two register values drive every lane of the device together, so the lanes always share one pull-up setting and one pull-down setting.

Each register counts drive steps and saturates at both ends, so extra commands at a limit do nothing. A code that falls outside the defined set is rejected and raises a one-cycle flag. A beat on which the lanes disagree is also rejected, with its own one-cycle flag. Leaving adjust mode throws away any partly collected code.

Top module: `odc_strength_adjuster`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `pu_step` equals parameter `PU_INIT`, `pd_step` equals `PD_INIT`, and both `reserved_err` and `lane_err` are low.
- R2: A beat is taken on a rising clock edge only when `adjust_en` and `beat_vld` are both high. Cycles with `beat_vld` low between beats neither advance nor clear the burst. The first beat taken is the code bit written leftmost (DT0) and the fourth is the rightmost (DT3).
- R3: A code is written DT0 DT1 DT2 DT3. The pull-up field is the pair DT2,DT3 and the pull-down field is the pair DT0,DT1. In each field, 00 holds the register, 01 raises it by one step and 10 lowers it by one step. This gives 0000 no change, 0001 pull-up up, 0010 pull-up down, 0100 pull-down up, 1000 pull-down down, 0101 both up, 0110 pull-up down and pull-down up, 1001 pull-up up and pull-down down, and 1010 both down.
- R4: Any code in which either field is 11 is reserved. It changes neither register and raises `reserved_err` for exactly one cycle.
- R5: Both registers take their new values together on the clock edge that takes the fourth beat, so the new values are visible in the cycle after that beat. `reserved_err` follows the same timing.
- R6: Each register holds steps 0 to 15. A raise at 15 or a lower at 0 leaves that register unchanged, and the other register still follows its own field.
- R7: If the lanes do not all carry the same value on a beat that is taken, `lane_err` is high for exactly the next cycle, the partial code is dropped, neither register changes, and the next beat starts a new burst as DT0.
- R8: Beats presented while `adjust_en` is low are ignored. Dropping `adjust_en` in the middle of a burst discards the beats already collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adjust_en | input | 1 | Adjust mode active |
| beat_vld | input | 1 | A code beat is present on `dq` this cycle |
| dq | input | LANES | Data lanes, all carrying the current code bit |
| pu_step | output | STEP_W | Pull-up drive step shared by all lanes |
| pd_step | output | STEP_W | Pull-down drive step shared by all lanes |
| reserved_err | output | 1 | One-cycle pulse: a reserved code was received |
| lane_err | output | 1 | One-cycle pulse: the lanes disagreed on a beat |

## Verification
The bench builds the block with four lanes and with the lane-agreement variant enabled, so a single differing lane is enough to reach the mismatch path. It starts pull-up at step 13 and pull-down at step 2. With those starting points, a handful of bursts drives each register into both of its limits, and the walk through all sixteen codes exercises every field combination near a boundary.

// File: rtl/odc_adj_pkg.sv
package odc_adj_pkg;

   localparam int CODE_BEATS = 4;
   localparam int FIELD_W    = 2;
   localparam int NUM_LEGS   = 2;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DOWN = 2'b10
   } step_cmd_e;

   localparam int LEG_PULLUP   = 0;
   localparam int LEG_PULLDOWN = 1;

endpackage

// File: rtl/odc_beat_collector.sv
module odc_beat_collector
   import odc_adj_pkg::*;
#(
   parameter int LANES      = 8,
   parameter bit LANE_CHECK = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  adjust_en,
   input  logic                  beat_vld,
   input  logic [LANES-1:0]      dq,
   output logic [CODE_BEATS-1:0] code,
   output logic                  code_vld,
   output logic                  mismatch
);

   localparam int CNT_W = $clog2(CODE_BEATS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CODE_BEATS - 1);

   logic [CNT_W-1:0]      beat_idx;
   logic [CODE_BEATS-2:0] held_bits;
   logic                  lanes_agree;
   logic                  beat_take;
   logic                  lane_bit;

   initial begin
      if (LANES < 1) $error("odc_beat_collector: LANES must be at least 1");
      if (CODE_BEATS != 4) $error("odc_beat_collector: code must be four beats");
   end

   generate
      if (LANE_CHECK && LANES > 1) begin : g_agree
         assign lanes_agree = (&dq) | ~(|dq);
      end else begin : g_trust
         assign lanes_agree = 1'b1;
      end
   endgenerate

   assign lane_bit  = dq[0];
   assign beat_take = adjust_en & beat_vld;
   assign mismatch  = beat_take & ~lanes_agree;
   assign code_vld  = beat_take & lanes_agree & (beat_idx == LAST_IDX);
   assign code      = {held_bits, lane_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_idx  <= '0;
         held_bits <= '0;
      end else if (!adjust_en) begin
         beat_idx  <= '0;
      end else if (beat_take) begin
         if (!lanes_agree || beat_idx == LAST_IDX) begin
            beat_idx <= '0;
         end else begin
            beat_idx <= beat_idx + 1'b1;
         end
         if (lanes_agree) begin
            held_bits <= {held_bits[CODE_BEATS-3:0], lane_bit};
         end
      end
   end

endmodule

// File: rtl/odc_code_decoder.sv
module odc_code_decoder
   import odc_adj_pkg::*;
(
   input  logic [CODE_BEATS-1:0] code,
   output step_cmd_e             leg_cmd [NUM_LEGS],
   output logic                  reserved
);

   logic [NUM_LEGS-1:0] field_bad;

   genvar g;
   generate
      for (g = 0; g < NUM_LEGS; g++) begin : g_field
         logic [FIELD_W-1:0] fld;
         assign fld = code[g*FIELD_W +: FIELD_W];
         always_comb begin
            field_bad[g] = 1'b0;
            case (fld)
               2'b01:   leg_cmd[g] = STEP_UP;
               2'b10:   leg_cmd[g] = STEP_DOWN;
               2'b11: begin
                  leg_cmd[g]   = STEP_HOLD;
                  field_bad[g] = 1'b1;
               end
               default: leg_cmd[g] = STEP_HOLD;
            endcase
         end
      end
   endgenerate

   assign reserved = |field_bad;

endmodule

// File: rtl/odc_step_register.sv
module odc_step_register
   import odc_adj_pkg::*;
#(
   parameter int              STEP_W = 4,
   parameter logic [STEP_W-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              apply,
   input  step_cmd_e         cmd,
   output logic [STEP_W-1:0] step
);

   localparam logic [STEP_W-1:0] STEP_MAX = {STEP_W{1'b1}};
   localparam logic [STEP_W-1:0] STEP_MIN = '0;

   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] step_d;

   always_comb begin
      step_d = step_q;
      if (apply) begin
         case (cmd)
            STEP_UP:   if (step_q != STEP_MAX) step_d = step_q + 1'b1;
            STEP_DOWN: if (step_q != STEP_MIN) step_d = step_q - 1'b1;
            default:   step_d = step_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= INIT;
      else        step_q <= step_d;
   end

   assign step = step_q;

endmodule

// File: rtl/odc_strength_adjuster.sv
module odc_strength_adjuster
   import odc_adj_pkg::*;
#(
   parameter int              LANES      = 8,
   parameter int              STEP_W     = 4,
   parameter logic [STEP_W-1:0] PU_INIT  = 4'd8,
   parameter logic [STEP_W-1:0] PD_INIT  = 4'd8,
   parameter bit              LANE_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adjust_en,
   input  logic              beat_vld,
   input  logic [LANES-1:0]  dq,
   output logic [STEP_W-1:0] pu_step,
   output logic [STEP_W-1:0] pd_step,
   output logic              reserved_err,
   output logic              lane_err
);

   logic [CODE_BEATS-1:0] code;
   logic                  code_vld;
   logic                  mismatch;
   step_cmd_e             leg_cmd [NUM_LEGS];
   logic                  reserved;
   logic                  apply;
   logic [STEP_W-1:0]     leg_step [NUM_LEGS];

   initial begin
      if (STEP_W != 4) $error("odc_strength_adjuster: STEP_W must be 4 for sixteen steps");
   end

   odc_beat_collector #(
      .LANES      (LANES),
      .LANE_CHECK (LANE_CHECK)
   ) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .adjust_en (adjust_en),
      .beat_vld  (beat_vld),
      .dq        (dq),
      .code      (code),
      .code_vld  (code_vld),
      .mismatch  (mismatch)
   );

   odc_code_decoder u_decode (
      .code     (code),
      .leg_cmd  (leg_cmd),
      .reserved (reserved)
   );

   assign apply = code_vld & ~reserved;

   genvar g;
   generate
      for (g = 0; g < NUM_LEGS; g++) begin : g_leg
         localparam logic [STEP_W-1:0] LEG_INIT = (g == LEG_PULLUP) ? PU_INIT : PD_INIT;
         odc_step_register #(
            .STEP_W (STEP_W),
            .INIT   (LEG_INIT)
         ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .apply (apply),
            .cmd   (leg_cmd[g]),
            .step  (leg_step[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reserved_err <= 1'b0;
         lane_err     <= 1'b0;
      end else begin
         reserved_err <= code_vld & reserved;
         lane_err     <= mismatch;
      end
   end

   assign pu_step = leg_step[LEG_PULLUP];
   assign pd_step = leg_step[LEG_PULLDOWN];

endmodule

// File: rtl/odc_adjust_checker.sv
module odc_adjust_checker #(
   parameter int LANES  = 8,
   parameter int STEP_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adjust_en,
   input logic              beat_vld,
   input logic [LANES-1:0]  dq,
   input logic [STEP_W-1:0] pu_step,
   input logic [STEP_W-1:0] pd_step,
   input logic              reserved_err,
   input logic              lane_err
);

   localparam logic [STEP_W-1:0] TOP = {STEP_W{1'b1}};

   p_reserved_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_err |-> ($stable(pu_step) && $stable(pd_step)));

   p_reserved_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reserved_err |=> !reserved_err);

   p_update_on_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(pu_step) || !$stable(pd_step)) |-> $past(adjust_en && beat_vld));

   p_pu_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pu_step) |->
         (($past(pu_step) != TOP && pu_step == $past(pu_step) + 1'b1) ||
          ($past(pu_step) != '0  && pu_step == $past(pu_step) - 1'b1)));

   p_pd_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pd_step) |->
         (($past(pd_step) != TOP && pd_step == $past(pd_step) + 1'b1) ||
          ($past(pd_step) != '0  && pd_step == $past(pd_step) - 1'b1)));

   p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lane_err |-> ($stable(pu_step) && $stable(pd_step) && !reserved_err));

   p_lane_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lane_err |-> $past(adjust_en && beat_vld));

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(adjust_en) |-> ($stable(pu_step) && $stable(pd_step) && !lane_err));

endmodule

bind odc_strength_adjuster odc_adjust_checker #(
   .LANES  (LANES),
   .STEP_W (STEP_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adjust_en    (adjust_en),
   .beat_vld     (beat_vld),
   .dq           (dq),
   .pu_step      (pu_step),
   .pd_step      (pd_step),
   .reserved_err (reserved_err),
   .lane_err     (lane_err)
);

// File: tb/tb_odc_strength_adjuster.sv
module tb_odc_strength_adjuster;

   localparam int CLK_PERIOD = 10;
   localparam int LANES      = 4;
   localparam int PU0        = 13;
   localparam int PD0        = 2;
   localparam int WATCHDOG   = 20000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             adjust_en = 1'b0;
   logic             beat_vld = 1'b0;
   logic [LANES-1:0] dq = '0;
   logic [3:0]       pu_step, pd_step;
   logic             reserved_err, lane_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   string cur_req = "R1";

   int m_pu = PU0, m_pd = PD0, m_cnt = 0, m_code = 0;
   bit m_res = 0, m_lane = 0;

   odc_strength_adjuster #(
      .LANES (LANES), .STEP_W (4),
      .PU_INIT (4'(PU0)), .PD_INIT (4'(PD0)), .LANE_CHECK (1'b1)
   ) dut (
      .clk (clk), .rst_n (rst_n), .adjust_en (adjust_en), .beat_vld (beat_vld),
      .dq (dq), .pu_step (pu_step), .pd_step (pd_step),
      .reserved_err (reserved_err), .lane_err (lane_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int clamp(input int v);
      if (v > 15) return 15;
      if (v < 0) return 0;
      return v;
   endfunction

   // Behavioural reference: counts beats, builds the code as an integer.
   always @(posedge clk) begin
      m_res = 0;
      m_lane = 0;
      if (!rst_n) begin
         m_pu = PU0; m_pd = PD0; m_cnt = 0; m_code = 0;
      end else if (!adjust_en) begin
         m_cnt = 0; m_code = 0;
      end else if (beat_vld) begin
         if (dq != '0 && dq != '1) begin
            m_lane = 1; m_cnt = 0; m_code = 0;
         end else begin
            m_code = m_code * 2 + (dq[0] ? 1 : 0);
            m_cnt++;
            if (m_cnt == 4) begin
               case (m_code)
                  0:  ;
                  1:  m_pu = clamp(m_pu + 1);
                  2:  m_pu = clamp(m_pu - 1);
                  4:  m_pd = clamp(m_pd + 1);
                  8:  m_pd = clamp(m_pd - 1);
                  5:  begin m_pu = clamp(m_pu + 1); m_pd = clamp(m_pd + 1); end
                  6:  begin m_pu = clamp(m_pu - 1); m_pd = clamp(m_pd + 1); end
                  9:  begin m_pu = clamp(m_pu + 1); m_pd = clamp(m_pd - 1); end
                  10: begin m_pu = clamp(m_pu - 1); m_pd = clamp(m_pd - 1); end
                  default: m_res = 1;
               endcase
               m_cnt = 0; m_code = 0;
            end
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare against the model on every falling edge.
   always @(negedge clk) begin
      cycles++;
      chk(cur_req, int'(pu_step), m_pu, "pu_step");
      chk(cur_req, int'(pd_step), m_pd, "pd_step");
      chk(cur_req, int'(reserved_err), int'(m_res), "reserved_err");
      chk(cur_req, int'(lane_err), int'(m_lane), "lane_err");
      if (cycles > WATCHDOG) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         beat_vld = 1'b0;
      end
   endtask

   task automatic beat(input logic b);
      @(negedge clk);
      adjust_en = 1'b1;
      beat_vld  = 1'b1;
      dq        = {LANES{b}};
   endtask

   task automatic burst(input logic [3:0] c);
      for (int i = 3; i >= 0; i--) beat(c[i]);
      idle(2);
   endtask

   initial begin
      idle(3);
      chk("R1", int'(pu_step), PU0, "reset pu");
      chk("R1", int'(pd_step), PD0, "reset pd");
      chk("R1", int'(reserved_err) + int'(lane_err), 0, "reset flags");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(pu_step), PU0, "post-reset pu");

      // R5: latency of the fourth beat
      cur_req = "R5";
      beat(0); beat(0); beat(0); beat(1);
      @(negedge clk); beat_vld = 1'b0;
      chk("R5", int'(pu_step), PU0 + 1, "pu one cycle after fourth beat");
      idle(2);

      // R3 / R4: every code once
      cur_req = "R3";
      for (int c = 0; c < 16; c++) begin
         cur_req = (c == 3 || c == 7 || c >= 11 || c == 12) ? "R4" : "R3";
         burst(4'(c));
      end

      // R2: gaps between beats
      cur_req = "R2";
      beat(0); idle(3); beat(1); idle(1); beat(0); idle(2); beat(0);
      idle(2);
      chk("R2", int'(pd_step), m_pd, "gapped burst pd");

      // R6: saturation at both ends, each leg
      cur_req = "R6";
      for (int i = 0; i < 18; i++) burst(4'b0001);
      chk("R6", int'(pu_step), 15, "pull-up top");
      for (int i = 0; i < 18; i++) burst(4'b0010);
      chk("R6", int'(pu_step), 0, "pull-up bottom");
      for (int i = 0; i < 18; i++) burst(4'b0100);
      chk("R6", int'(pd_step), 15, "pull-down top");
      burst(4'b0110);
      chk("R6", int'(pd_step), 15, "pd held at top, pu held at bottom");
      chk("R6", int'(pu_step), 0, "pu at bottom with mixed code");
      for (int i = 0; i < 18; i++) burst(4'b1000);
      chk("R6", int'(pd_step), 0, "pull-down bottom");
      burst(4'b1001);
      chk("R6", int'(pu_step), 1, "pu rises while pd pinned");

      // R7: lane mismatch mid-burst, then a clean burst
      cur_req = "R7";
      beat(0); beat(1);
      @(negedge clk); beat_vld = 1'b1; dq = 4'b0100;
      @(negedge clk); beat_vld = 1'b0;
      chk("R7", int'(lane_err), 1, "mismatch flag");
      idle(1);
      burst(4'b0101);
      chk("R7", int'(pu_step), 2, "restart after mismatch pu");
      chk("R7", int'(pd_step), 1, "restart after mismatch pd");

      // R8: ignored beats and aborted burst
      cur_req = "R8";
      @(negedge clk); adjust_en = 1'b0; beat_vld = 1'b1; dq = '1;
      idle(1);
      @(negedge clk); beat_vld = 1'b1; dq = '0;
      @(negedge clk); beat_vld = 1'b1; dq = 4'b0011;
      idle(2);
      chk("R8", int'(lane_err), 0, "no flag while disabled");
      beat(0); beat(0); beat(0);
      @(negedge clk); adjust_en = 1'b0; beat_vld = 1'b0;
      idle(2);
      burst(4'b0001);
      chk("R8", int'(pu_step), 3, "aborted burst discarded");
      idle(4);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule